// File: doc/BRIEF.md
# Two-Layer Network Layer Selector

This block sits at the injection point of one node in a system whose network is split over two physically separate layers: a mesh on the processor die and a sub-network routed through the interposer underneath. For every outgoing packet it picks the layer the packet enters, and it hands the descriptor on together with that one-bit choice through a single register stage with a valid/ready handshake.

Packets bound for memory always go straight down to the interposer. Coherence packets stay on the die unless one of two rules moves them. The first rule is load balancing. The node keeps a running average of the latency of packets it receives back on each layer. A coherence packet moves when the die average exceeds the interposer average by more than a programmable threshold. The second rule is express mode. When it is enabled, a destination whose interposer route is shorter is sent down whatever the load. Both rules apply only to destinations whose interposer route never doubles back. That restriction keeps diverted traffic deadlock-safe.

A small table set by parameters gives two bits for each destination: whether the route is eligible (it does not double back) and whether it is shorter. A configuration write port loads the threshold and the two enable bits.

Top module: `layer_select`

## Requirements
- R1: A descriptor of class memory (in_cls = 1) is always issued with out_layer = 1 (interposer). Layer code 0 means the on-die mesh.
- R2: A coherence descriptor (in_cls = 0) is issued with out_layer = 0 when neither the express rule nor the balance rule applies to it.
- R3: Each layer keeps an accumulator A with three fractional bits. On every latency sample for that layer (smp_layer 0 = die, 1 = interposer), A is updated to A - (A >> 3) + sample. The layer's estimate is A >> 3. Without a sample the accumulator does not change.
- R4: When balancing is enabled and the destination is eligible, a coherence descriptor gets out_layer = 1 exactly when die estimate > interposer estimate + threshold. When the difference equals the threshold, the descriptor stays on die.
- R5: A coherence descriptor whose destination bit in the parameter ELIGIBLE_MASK is 0 always gets out_layer = 0, whatever the load or mode.
- R6: When express mode is enabled, a coherence descriptor whose destination bit is set in both ELIGIBLE_MASK and SHORT_MASK gets out_layer = 1 regardless of the estimates.
- R7: After reset the threshold is 10, balancing is enabled, express mode is disabled, both accumulators are zero and out_valid is 0.
- R8: While out_valid = 1 and out_ready = 0, the output descriptor and out_layer hold their values.
- R9: When cfg_we = 1 at a clock edge, the threshold, express enable and balance enable take the values on cfg_thresh, cfg_express and cfg_balance. Descriptors accepted at later edges use the new values.
- R10: in_ready = !out_valid || out_ready. A descriptor accepted at an edge appears on the outputs after that edge. Its layer is decided from the estimates and configuration held before that edge.
- R11: When balancing is disabled and the express rule does not apply, a coherence descriptor gets out_layer = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor accepted when high together with in_valid |
| in_cls | input | 1 | Traffic class: 0 coherence, 1 memory |
| in_src | input | 4 | Source identifier |
| in_dst | input | 4 | Destination identifier |
| out_valid | output | 1 | Output descriptor present |
| out_ready | input | 1 | Downstream takes the output descriptor |
| out_cls | output | 1 | Class of the issued descriptor |
| out_src | output | 4 | Source of the issued descriptor |
| out_dst | output | 4 | Destination of the issued descriptor |
| out_layer | output | 1 | Layer choice: 0 on-die mesh, 1 interposer |
| smp_valid | input | 1 | A latency sample is present |
| smp_layer | input | 1 | Layer the sampled packet travelled on |
| smp_lat | input | 8 | Observed latency in cycles |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_thresh | input | 8 | New balancing threshold |
| cfg_express | input | 1 | New express mode enable |
| cfg_balance | input | 1 | New balancing enable |

## Verification
The assertions take for granted that the downstream side follows the handshake. The output is expected to stay pending until out_ready is high, and samples and configuration writes may arrive in any cycle, including the cycle in which a descriptor is accepted. The stimulus stalls out_ready at random and changes in_valid and the descriptor fields during stalls, so the hold property is exercised. Samples are issued in phases with the die latency high, the interposer latency high or the two balanced, so the balance comparison falls on both sides. Directed cases bring the two averages to a difference equal to the threshold, and then one above it.

// File: rtl/lsel_pkg.sv
package lsel_pkg;

    localparam int LAT_W     = 8;
    localparam int ID_W      = 4;
    localparam int AVG_SHIFT = 3;
    localparam int ACC_W     = LAT_W + AVG_SHIFT;

    typedef enum logic {LAYER_DIE = 1'b0, LAYER_IP = 1'b1} layer_e;
    typedef enum logic {CLS_COH = 1'b0, CLS_MEM = 1'b1} cls_e;

    typedef struct packed {
        cls_e            cls;
        logic [ID_W-1:0] src;
        logic [ID_W-1:0] dst;
    } desc_t;

    typedef struct packed {
        logic [LAT_W-1:0] thresh;
        logic             express_en;
        logic             balance_en;
    } cfg_t;

    function automatic logic over_margin(input logic [LAT_W-1:0] die_est,
                                         input logic [LAT_W-1:0] ip_est,
                                         input logic [LAT_W-1:0] margin);
        logic [LAT_W:0] lhs;
        logic [LAT_W:0] rhs;
        lhs = {1'b0, die_est};
        rhs = {1'b0, ip_est} + {1'b0, margin};
        return lhs > rhs;
    endfunction

endpackage

// File: rtl/lsel_lat_avg.sv
module lsel_lat_avg
    import lsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [LAT_W-1:0] sample,
    output logic [LAT_W-1:0] estimate
);
    logic [ACC_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (upd) begin
            acc <= acc - (acc >> AVG_SHIFT) + ACC_W'(sample);
        end
    end

    assign estimate = acc[ACC_W-1:AVG_SHIFT];
endmodule

// File: rtl/lsel_path_table.sv
module lsel_path_table
    import lsel_pkg::*;
#(
    parameter int          NUM_DST       = 1 << ID_W,
    parameter logic [NUM_DST-1:0] ELIGIBLE_MASK = '0,
    parameter logic [NUM_DST-1:0] SHORT_MASK    = '0
) (
    input  logic [ID_W-1:0] dst,
    output logic            eligible,
    output logic            shorter
);
    assign eligible = ELIGIBLE_MASK[dst];
    assign shorter  = SHORT_MASK[dst];
endmodule

// File: rtl/lsel_policy.sv
module lsel_policy
    import lsel_pkg::*;
(
    input  cls_e             cls,
    input  logic             eligible,
    input  logic             shorter,
    input  cfg_t             cfg,
    input  logic [LAT_W-1:0] die_est,
    input  logic [LAT_W-1:0] ip_est,
    output layer_e           layer
);
    always_comb begin
        layer = LAYER_DIE;
        if (cls == CLS_MEM) begin
            layer = LAYER_IP;
        end else if (eligible) begin
            if (cfg.express_en && shorter) begin
                layer = LAYER_IP;
            end else if (cfg.balance_en && over_margin(die_est, ip_est, cfg.thresh)) begin
                layer = LAYER_IP;
            end
        end
    end
endmodule

// File: rtl/layer_select.sv
module layer_select
    import lsel_pkg::*;
#(
    parameter int                      NUM_DST       = 1 << ID_W,
    parameter logic [NUM_DST-1:0]      ELIGIBLE_MASK = 16'h03F7,
    parameter logic [NUM_DST-1:0]      SHORT_MASK    = 16'h0C0C,
    parameter logic [LAT_W-1:0]        THRESH_RESET  = 8'd10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_cls,
    input  logic [ID_W-1:0]  in_src,
    input  logic [ID_W-1:0]  in_dst,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_cls,
    output logic [ID_W-1:0]  out_src,
    output logic [ID_W-1:0]  out_dst,
    output logic             out_layer,
    input  logic             smp_valid,
    input  logic             smp_layer,
    input  logic [LAT_W-1:0] smp_lat,
    input  logic             cfg_we,
    input  logic [LAT_W-1:0] cfg_thresh,
    input  logic             cfg_express,
    input  logic             cfg_balance
);
    localparam int NUM_LAYERS = 2;

    cfg_t             cfg_q;
    desc_t            desc_q;
    layer_e           layer_q;
    logic             valid_q;
    logic [LAT_W-1:0] est [NUM_LAYERS];
    logic             eligible;
    logic             shorter;
    layer_e           layer_d;
    desc_t            desc_in;

    assign desc_in = '{cls: cls_e'(in_cls), src: in_src, dst: in_dst};

    for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_avg
        lsel_lat_avg u_avg (
            .clk      (clk),
            .rst      (rst),
            .upd      (smp_valid && (smp_layer == 1'(g))),
            .sample   (smp_lat),
            .estimate (est[g])
        );
    end

    lsel_path_table #(
        .NUM_DST       (NUM_DST),
        .ELIGIBLE_MASK (ELIGIBLE_MASK),
        .SHORT_MASK    (SHORT_MASK)
    ) u_tab (
        .dst      (in_dst),
        .eligible (eligible),
        .shorter  (shorter)
    );

    lsel_policy u_pol (
        .cls      (desc_in.cls),
        .eligible (eligible),
        .shorter  (shorter),
        .cfg      (cfg_q),
        .die_est  (est[LAYER_DIE]),
        .ip_est   (est[LAYER_IP]),
        .layer    (layer_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{thresh: THRESH_RESET, express_en: 1'b0, balance_en: 1'b1};
        end else if (cfg_we) begin
            cfg_q <= '{thresh: cfg_thresh, express_en: cfg_express, balance_en: cfg_balance};
        end
    end

    assign in_ready = !valid_q || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            desc_q  <= '0;
            layer_q <= LAYER_DIE;
        end else if (in_ready) begin
            valid_q <= in_valid;
            if (in_valid) begin
                desc_q  <= desc_in;
                layer_q <= layer_d;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_cls   = desc_q.cls;
    assign out_src   = desc_q.src;
    assign out_dst   = desc_q.dst;
    assign out_layer = layer_q;
endmodule

// File: rtl/lsel_checker.sv
module lsel_checker
    import lsel_pkg::*;
#(
    parameter int                 NUM_DST       = 1 << ID_W,
    parameter logic [NUM_DST-1:0] ELIGIBLE_MASK = '0
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_cls,
    input logic [ID_W-1:0]  out_src,
    input logic [ID_W-1:0]  out_dst,
    input logic             out_layer,
    input logic             smp_valid,
    input logic [LAT_W-1:0] est_die,
    input logic [LAT_W-1:0] est_ip
);
    p_mem_on_ip_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cls == CLS_MEM) |-> out_layer == LAYER_IP);

    p_inelig_die_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cls == CLS_COH && !ELIGIBLE_MASK[out_dst]) |-> out_layer == LAYER_DIE);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_layer) && $stable(out_cls)
                                       && $stable(out_src) && $stable(out_dst)));

    p_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    p_est_still_r3: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ($stable(est_die) && $stable(est_ip)));
endmodule

bind layer_select lsel_checker #(
    .NUM_DST       (NUM_DST),
    .ELIGIBLE_MASK (ELIGIBLE_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_cls   (out_cls),
    .out_src   (out_src),
    .out_dst   (out_dst),
    .out_layer (out_layer),
    .smp_valid (smp_valid),
    .est_die   (est[0]),
    .est_ip    (est[1])
);

// File: tb/sim_layer_select.sv
module sim_layer_select;
    localparam logic [15:0] ELIG  = 16'h03F7;
    localparam logic [15:0] SHORT = 16'h0C0C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 0, in_cls = 0, out_ready = 0, smp_valid = 0, smp_layer = 0;
    logic cfg_we = 0, cfg_express = 0, cfg_balance = 0;
    logic [3:0] in_src = 0, in_dst = 0;
    logic [7:0] smp_lat = 0, cfg_thresh = 0;
    logic in_ready, out_valid, out_cls, out_layer;
    logic [3:0] out_src, out_dst;

    always #2 clk = ~clk;

    layer_select u0 (.*);

    int checks = 0;
    int errors = 0;

    int unsigned acc_m [2];
    int unsigned thr_m;
    bit ex_m, bal_m;
    bit ev_m, el_m, ec_m;
    logic [3:0] es_m, ed_m;
    string etag;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit decide(input bit cls, input logic [3:0] dst, output string tag);
        int unsigned de, ie;
        de = acc_m[0] >> 3;
        ie = acc_m[1] >> 3;
        if (cls) begin tag = "R1"; return 1; end
        if (!ELIG[dst]) begin tag = "R5"; return 0; end
        if (ex_m && SHORT[dst]) begin tag = "R6"; return 1; end
        if (!bal_m) begin tag = "R11"; return 0; end
        if (de > ie + thr_m) begin tag = "R4"; return 1; end
        tag = (de == ie + thr_m) ? "R4" : "R2";
        return 0;
    endfunction

    task automatic step(input bit iv, input bit cls, input logic [3:0] src, input logic [3:0] dst,
                        input bit ordy, input bit sv, input bit sl, input logic [7:0] lat,
                        input bit we, input logic [7:0] wthr, input bit wex, input bit wbal);
        bit rdy, nl;
        string ntag;
        in_valid = iv; in_cls = cls; in_src = src; in_dst = dst; out_ready = ordy;
        smp_valid = sv; smp_layer = sl; smp_lat = lat;
        cfg_we = we; cfg_thresh = wthr; cfg_express = wex; cfg_balance = wbal;
        #1;
        rdy = !ev_m || ordy;
        chk(in_ready == rdy, "R10 in_ready", in_ready, rdy);
        if (rdy) begin
            if (iv) begin
                nl = decide(cls, dst, ntag);
                el_m = nl; etag = ntag; ec_m = cls; es_m = src; ed_m = dst;
            end
            ev_m = iv;
        end
        if (sv) acc_m[sl] = acc_m[sl] - (acc_m[sl] >> 3) + lat;
        if (we) begin thr_m = wthr; ex_m = wex; bal_m = wbal; end
        @(negedge clk);
        chk(out_valid == ev_m, "R10 out_valid", out_valid, ev_m);
        if (ev_m && out_valid) begin
            chk(out_layer == el_m, etag, out_layer, el_m);
            chk({out_cls, out_src, out_dst} == {ec_m, es_m, ed_m}, "R8 descriptor",
                {out_cls, out_src, out_dst}, {ec_m, es_m, ed_m});
        end
    endtask

    task automatic pkt(input bit cls, input logic [3:0] dst);
        step(1, cls, 4'd5, dst, 1, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic samp(input bit sl, input logic [7:0] lat);
        step(0, 0, 0, 0, 1, 1, sl, lat, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'h5EED1234;
        void'($urandom(seed));
        acc_m[0] = 0; acc_m[1] = 0;
        thr_m = 10; ex_m = 0; bal_m = 1; ev_m = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R7: reset state
        chk(out_valid == 1'b0, "R7 out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R7 in_ready", in_ready, 1);
        @(negedge clk);
        pkt(0, 4'd0);            // R2: coherence stays on die, empty estimates
        pkt(1, 4'd0);            // R1: memory goes down
        pkt(1, 4'd3);            // R1
        for (int i = 0; i < 64; i++) samp(0, 8'd20);  // R3 die average to 20
        for (int i = 0; i < 64; i++) samp(1, 8'd10);  // R3 interposer average to 10
        pkt(0, 4'd0);            // R7/R4: difference equals reset threshold 10 -> die
        step(0, 0, 0, 0, 1, 0, 0, 0, 1, 8'd9, 0, 1);  // R9 threshold 9
        pkt(0, 4'd0);            // R4: 10 > 9 -> interposer
        pkt(0, 4'd3);            // R5: ineligible stays on die
        step(0, 0, 0, 0, 1, 0, 0, 0, 1, 8'd9, 0, 0);  // R9 balance off
        pkt(0, 4'd0);            // R11
        for (int i = 0; i < 64; i++) samp(0, 8'd10);
        step(0, 0, 0, 0, 1, 0, 0, 0, 1, 8'd200, 1, 1); // R9 express on
        pkt(0, 4'd2);            // R6 short and eligible
        pkt(0, 4'd3);            // R5 short but ineligible
        pkt(0, 4'd1);            // R2 eligible, not short
        // R8: stall while the offered descriptor keeps changing
        step(1, 0, 4'd7, 4'd2, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) step(1, i[0], 4'(i), 4'(i + 8), 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        // Random phases
        for (int i = 0; i < 6000; i++) begin
            int ph;
            logic [7:0] lat;
            bit sl;
            ph = (i / 500) % 3;
            sl = 1'($urandom_range(0, 1));
            case (ph)
                0: lat = sl ? 8'($urandom_range(5, 20)) : 8'($urandom_range(40, 120));
                1: lat = sl ? 8'($urandom_range(40, 120)) : 8'($urandom_range(5, 20));
                default: lat = 8'($urandom_range(20, 40));
            endcase
            step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), sl, lat,
                 $urandom_range(0, 199) == 0, 8'($urandom_range(0, 40)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule